// File: doc/BRIEF.md
# Execute Re-Check Stage

This stage sits in the retirement path of a checker pipeline and re-executes one integer ALU operation so that a value predicted by a complex, possibly faulty core is confirmed before it is allowed to commit. In check mode it takes the operand values and opcode that the core supplied, recomputes the result on its own functional units and compares that value with the core's predicted result. On any disagreement it raises a fault flag, and the value it presents for commit is always its own recomputed one.

In recovery mode the pipeline is rewired into a serial chain: a routing multiplexer feeds the stage from the previous checker stage's outputs instead of the core record. The stage then simply executes and forwards its result. The compare logic stays in place but is masked, because operands arriving on that path are correct by construction. A stall input freezes the stage whenever any other checker stage is blocked.

Top module: `exec_check_stage`

## Requirements
- R1: While rstN is low, and in the first cycle after it, outValid, outFault, outResult and outDest are all zero.
- R2: A record accepted at a rising edge (inValid high, stall low) appears with outValid high right after that same edge, one cycle of latency.
- R3: The opcode field is 4 bits wide: 0 add, 1 subtract (A minus B), 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 signed set-less-than giving 1 or 0. Shifts use only the low 5 bits of operand B.
- R4: In check mode (recoverMode low), the core operands are used, and a recomputed value that differs from predResult sets outFault. outResult then carries the recomputed value.
- R5: In check mode, a recomputed value equal to predResult leaves outFault low, and outResult equals that value.
- R6: Opcodes 8 to 15 are unknown: in check mode they set outFault and give outResult zero, whatever predResult holds.
- R7: In recovery mode (recoverMode high), the operands come from prevOpA and prevOpB, the core operands and predResult have no effect, and outFault is never set, even for an unknown opcode.
- R8: While stall is high at an edge, the input record is not taken and outValid, outFault, outResult and outDest keep their values.
- R9: outDest carries the destNum of the record whose result is shown.
- R10: After an edge with inValid low and stall low, outValid and outFault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | An input record is present |
| recoverMode | input | 1 | 1 selects serial recovery, 0 selects check mode |
| stall | input | 1 | Freeze the stage |
| coreOpA | input | 32 | Operand A from the core record |
| coreOpB | input | 32 | Operand B from the core record |
| prevOpA | input | 32 | Operand A from the previous checker stage |
| prevOpB | input | 32 | Operand B from the previous checker stage |
| opcode | input | 4 | ALU operation code |
| predResult | input | 32 | Result predicted by the core |
| destNum | input | 5 | Destination register number |
| outValid | output | 1 | Output record valid |
| outFault | output | 1 | Prediction mismatch or unknown opcode |
| outResult | output | 32 | Recomputed result to commit |
| outDest | output | 5 | Destination number of the output record |

## Verification
Two pairs of functions meet in one cycle. A stall can arrive while a record is waiting at the input. A recovery-mode record can also carry a wrong prediction and an unknown opcode, where the masked compare must win over the mismatch. The bench provokes both by driving a stalled valid record, then releasing it, and by sending recovery records with deliberately wrong predictions and garbage on the core operand ports. It judges them with a scoreboard that expects exactly one result per accepted edge, bit-identical held outputs on every stalled edge, and fault low for every recovery item.

// File: rtl/exck_pkg.sv
package exck_pkg;
  localparam int OPC_W   = 4;
  localparam int NUM_OPS = 8;
  localparam int SEL_W   = $clog2(NUM_OPS);

  localparam logic [OPC_W-1:0] OP_ADD = 4'd0;
  localparam logic [OPC_W-1:0] OP_SUB = 4'd1;
  localparam logic [OPC_W-1:0] OP_AND = 4'd2;
  localparam logic [OPC_W-1:0] OP_OR  = 4'd3;
  localparam logic [OPC_W-1:0] OP_XOR = 4'd4;
  localparam logic [OPC_W-1:0] OP_SLL = 4'd5;
  localparam logic [OPC_W-1:0] OP_SRL = 4'd6;
  localparam logic [OPC_W-1:0] OP_SLT = 4'd7;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // stage advances this edge
    logic load;     // a record is taken this edge
    logic checkEn;  // compare result may raise a fault
    logic selPrev;  // operands come from the previous checker stage
  } stageCtl_t;
endpackage

// File: rtl/exck_ctrl.sv
module exck_ctrl
  import exck_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      recoverMode,
  input  logic      stall,
  output stageCtl_t ctl,
  output logic      outValid
);

  always_comb begin
    ctl.capture = !stall;
    ctl.load    = !stall && inValid;
    ctl.checkEn = !stall && inValid && !recoverMode;
    ctl.selPrev = recoverMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            outValid <= 1'b0;
    else if (ctl.capture) outValid <= inValid;
  end

  // R2
  latency_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !stall) |=> outValid);

  // R10
  idle_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !stall) |=> !outValid);

endmodule

// File: rtl/exck_dpath.sv
module exck_dpath
  import exck_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageCtl_t         ctl,
  input  logic [DATA_W-1:0] coreOpA,
  input  logic [DATA_W-1:0] coreOpB,
  input  logic [DATA_W-1:0] prevOpA,
  input  logic [DATA_W-1:0] prevOpB,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] predResult,
  input  logic [DEST_W-1:0] destNum,
  output logic              outFault,
  output logic [DATA_W-1:0] outResult,
  output logic [DEST_W-1:0] outDest
);

  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] opA, opB;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] fuRes [NUM_OPS];
  logic              knownOp;
  logic [DATA_W-1:0] calc;
  logic              mismatch;

  // Routing multiplexer: core record or previous checker stage
  assign opA   = ctl.selPrev ? prevOpA : coreOpA;
  assign opB   = ctl.selPrev ? prevOpB : coreOpB;
  assign shamt = opB[SH_W-1:0];

  // Every functional unit sees the same operands
  always_comb begin
    fuRes[OP_ADD[SEL_W-1:0]] = opA + opB;
    fuRes[OP_SUB[SEL_W-1:0]] = opA - opB;
    fuRes[OP_AND[SEL_W-1:0]] = opA & opB;
    fuRes[OP_OR [SEL_W-1:0]] = opA | opB;
    fuRes[OP_XOR[SEL_W-1:0]] = opA ^ opB;
    fuRes[OP_SLL[SEL_W-1:0]] = opA << shamt;
    fuRes[OP_SRL[SEL_W-1:0]] = opA >> shamt;
    fuRes[OP_SLT[SEL_W-1:0]] = {{(DATA_W-1){1'b0}}, ($signed(opA) < $signed(opB))};
  end

  generate
    if (OPC_W > SEL_W) begin : g_wideOpc
      assign knownOp = (opcode[OPC_W-1:SEL_W] == '0);
    end else begin : g_fullOpc
      assign knownOp = 1'b1;
    end
  endgenerate

  assign calc     = knownOp ? fuRes[opcode[SEL_W-1:0]] : '0;
  assign mismatch = !knownOp || (calc != predResult);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outFault  <= 1'b0;
      outResult <= '0;
      outDest   <= '0;
    end else if (ctl.capture) begin
      if (ctl.load) begin
        outResult <= calc;
        outDest   <= destNum;
        outFault  <= ctl.checkEn && mismatch;
      end else begin
        outFault  <= 1'b0;
      end
    end
  end

  // R7
  recover_no_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.selPrev) |=> !outFault);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(outResult) && $stable(outFault) && $stable(outDest)));

  // R6
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.selPrev && opcode >= OPC_W'(NUM_OPS)) |=> (outFault && outResult == '0));

endmodule

// File: rtl/exec_check_stage.sv
module exec_check_stage
  import exck_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              recoverMode,
  input  logic              stall,
  input  logic [DATA_W-1:0] coreOpA,
  input  logic [DATA_W-1:0] coreOpB,
  input  logic [DATA_W-1:0] prevOpA,
  input  logic [DATA_W-1:0] prevOpB,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] predResult,
  input  logic [DEST_W-1:0] destNum,
  output logic              outValid,
  output logic              outFault,
  output logic [DATA_W-1:0] outResult,
  output logic [DEST_W-1:0] outDest
);

  stageCtl_t ctl;

  exck_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .recoverMode(recoverMode),
    .stall      (stall),
    .ctl        (ctl),
    .outValid   (outValid)
  );

  exck_dpath #(.DATA_W(DATA_W), .DEST_W(DEST_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .coreOpA   (coreOpA),
    .coreOpB   (coreOpB),
    .prevOpA   (prevOpA),
    .prevOpB   (prevOpB),
    .opcode    (opcode),
    .predResult(predResult),
    .destNum   (destNum),
    .outFault  (outFault),
    .outResult (outResult),
    .outDest   (outDest)
  );

  // R4
  fault_has_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outFault |-> outValid);

endmodule

// File: tb/test_exec_check_stage.sv
module test_exec_check_stage;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, recoverMode = 1'b0, stall = 1'b0;
  logic [31:0] coreOpA = '0, coreOpB = '0, prevOpA = '0, prevOpB = '0;
  logic [3:0]  opcode = '0;
  logic [31:0] predResult = '0;
  logic [4:0]  destNum = '0;
  logic        outValid, outFault;
  logic [31:0] outResult;
  logic [4:0]  outDest;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        fault;
    logic [4:0]  dest;
    string       tag;
  } expItem_t;

  expItem_t expQ [$];

  always #5 clk = ~clk;

  exec_check_stage i_exec_check_stage (
    .clk(clk), .rstN(rstN), .inValid(inValid), .recoverMode(recoverMode),
    .stall(stall), .coreOpA(coreOpA), .coreOpB(coreOpB), .prevOpA(prevOpA),
    .prevOpB(prevOpB), .opcode(opcode), .predResult(predResult),
    .destNum(destNum), .outValid(outValid), .outFault(outFault),
    .outResult(outResult), .outDest(outDest)
  );

  // Reference model: {known, value}
  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      4'd0: return {1'b1, a + b};
      4'd1: return {1'b1, a - b};
      4'd2: return {1'b1, a & b};
      4'd3: return {1'b1, a | b};
      4'd4: return {1'b1, a ^ b};
      4'd5: return {1'b1, a << b[4:0]};
      4'd6: return {1'b1, a >> b[4:0]};
      4'd7: return {1'b1, 31'd0, ($signed(a) < $signed(b))};
      default: return {1'b0, 32'd0};
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: one record per call, pushes the expectation when it will be accepted
  task automatic drive(input bit v, input bit rec, input bit st, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] pa, input logic [31:0] pb,
                       input logic [31:0] pred, input logic [4:0] dst, input string tag);
    logic [32:0] m;
    expItem_t it;
    @(negedge clk);
    inValid = v; recoverMode = rec; stall = st; opcode = op;
    coreOpA = a; coreOpB = b; prevOpA = pa; prevOpB = pb;
    predResult = pred; destNum = dst;
    if (v && !st) begin
      m = rec ? model(op, pa, pb) : model(op, a, b);
      it.res   = m[31:0];
      it.fault = !rec && (!m[32] || m[31:0] != pred);
      it.dest  = dst;
      it.tag   = tag;
      expQ.push_back(it);
    end
  endtask

  // Monitor
  logic        acceptedLast = 1'b0, stallLast = 1'b0;
  logic        prevValid = 1'b0, prevFault = 1'b0;
  logic [31:0] prevRes = '0;
  logic [4:0]  prevDest = '0;

  always @(posedge clk) begin
    acceptedLast <= rstN && inValid && !stall;
    stallLast    <= rstN && stall;
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (acceptedLast) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "unexpected output", 64'(outResult), 64'(0));
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(outValid == 1'b1, e.tag, "R2 valid", 64'(outValid), 64'(1));
          check(outResult == e.res, e.tag, "result", 64'(outResult), 64'(e.res));
          check(outFault == e.fault, e.tag, "fault", 64'(outFault), 64'(e.fault));
          check(outDest == e.dest, e.tag, "R9 dest", 64'(outDest), 64'(e.dest));
        end
      end else if (stallLast) begin
        check(outValid == prevValid && outFault == prevFault &&
              outResult == prevRes && outDest == prevDest, "R8", "held outputs",
              {outResult, 27'(outDest), outFault, outValid},
              {prevRes, 27'(prevDest), prevFault, prevValid});
      end else begin
        check(!outValid && !outFault, "R10", "idle valid/fault",
              64'({outValid, outFault}), 64'(0));
      end
    end
    prevValid = outValid; prevFault = outFault; prevRes = outResult; prevDest = outDest;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [32:0] m;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!outValid && !outFault && outResult == 0 && outDest == 0, "R1", "in reset",
          {outResult, 27'(outDest), outFault, outValid}, 64'(0));
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !outFault && outResult == 0 && outDest == 0, "R1", "after reset",
          {outResult, 27'(outDest), outFault, outValid}, 64'(0));

    // R3 / R5: each operation with a correct prediction, back to back
    for (int op = 0; op < 8; op++) begin
      logic [31:0] a, b;
      a = 32'h8000_0F0F + 32'(op * 32'h1357);
      b = 32'h0000_0023 + 32'(op);
      m = model(4'(op), a, b);
      drive(1, 0, 0, 4'(op), a, b, 32'hDEAD_BEEF, 32'h1, m[31:0], 5'(op + 1), "R3_R5");
    end
    // R3: signed compare with negative operand, shift by 31
    m = model(4'd7, 32'hFFFF_FFFE, 32'd1);
    drive(1, 0, 0, 4'd7, 32'hFFFF_FFFE, 32'd1, 0, 0, m[31:0], 5'd9, "R3_slt");
    drive(1, 0, 0, 4'd7, 32'd1, 32'hFFFF_FFFE, 0, 0, 32'd0, 5'd10, "R3_slt2");
    drive(1, 0, 0, 4'd6, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 32'd1, 5'd11, "R3_srl31");

    // R4: mismatches
    drive(1, 0, 0, 4'd0, 32'd5, 32'd7, 0, 0, 32'd13, 5'd12, "R4_add");
    drive(1, 0, 0, 4'd5, 32'd1, 32'd4, 0, 0, 32'd8, 5'd13, "R4_sll");

    // R10: idle gap
    drive(0, 0, 0, 4'd0, 0, 0, 0, 0, 0, 5'd0, "R10");
    drive(0, 0, 0, 4'd0, 0, 0, 0, 0, 0, 5'd0, "R10");

    // R6: unknown opcodes in check mode, one with pred 0
    drive(1, 0, 0, 4'd8, 32'd3, 32'd4, 0, 0, 32'd0, 5'd14, "R6_op8");
    drive(1, 0, 0, 4'd15, 32'd3, 32'd4, 0, 0, 32'h1234, 5'd15, "R6_op15");

    // R7: recovery with garbage core operands, wrong prediction, unknown op
    drive(1, 1, 0, 4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd100, 32'd1, 32'd0, 5'd16, "R7_sub");
    drive(1, 1, 0, 4'd9, 32'd1, 32'd2, 32'd3, 32'd4, 32'd77, 5'd17, "R7_unk");
    drive(1, 1, 0, 4'd4, 32'h0, 32'h0, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'h5, 5'd18, "R7_xor");

    // R8: stall with a pending faulting record, then release
    drive(1, 0, 0, 4'd2, 32'hFF00, 32'h0FF0, 0, 0, 32'h1, 5'd19, "R4_and");
    drive(1, 0, 1, 4'd0, 32'd1, 32'd1, 0, 0, 32'd9, 5'd20, "R8");
    drive(1, 1, 1, 4'd0, 32'd1, 32'd1, 32'd2, 32'd2, 32'd9, 5'd21, "R8");
    drive(0, 0, 1, 4'd0, 0, 0, 0, 0, 0, 5'd22, "R8");
    drive(1, 0, 0, 4'd0, 32'd1, 32'd1, 0, 0, 32'd2, 5'd20, "R8_release");
    drive(0, 0, 0, 4'd0, 0, 0, 0, 0, 0, 5'd0, "R10");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2", "scoreboard drained", 64'(expQ.size()), 64'(0));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule